// File: doc/BRIEF.md
# Debug Register Scan-Chain Access

This block is the target-side end of a serial debug path. It sits behind a test access port and reaches a small bank of debug registers: control, status, vector-catch, a host-exchange control/data pair, and two watchpoint units. During every data-register scan it holds a 38-bit frame. At capture it loads a read result. Shift moves the frame out one bit per clock while new bits come in. Update then performs the access the host sent in.

A write applies at once. A read is split over two scans. The scan that carries a read request only records the address. The capture of the following scan returns that register's contents. A read request for the exchange-data register counts as consuming the word held there. Because of this, a host that chains reads should finish the chain on a harmless address such as exchange control.

A small state machine decides whether an update is honoured. Its states are `S_IDLE`, `S_ARMED` and `S_SHIFT`:
- Capture moves any state to `S_ARMED`.
- Shift moves `S_ARMED` to `S_SHIFT`.
- Update moves `S_ARMED` or `S_SHIFT` back to `S_IDLE` and performs the access.
- In `S_IDLE` only capture leaves the state. Shift and update leave it unchanged, and an update there does nothing.
- Capture has priority over shift, and shift has priority over update.

Top module: `dbg_scan_access`

## Requirements
- R1: The frame is shifted least significant bit first. Bits 0–31 hold data, bits 32–36 hold the register address and bit 37 holds the write flag. After capture, `tdo` shows bit 0, and each tck edge with `shift_en` high moves `tdi` in at bit 37 and presents the next bit. A capture loads the pending read address into the address field and 0 into the flag.
- R2: An honoured update with flag 1 writes the data field into the addressed register. Only the register's low bits are kept.
- R3: An honoured update with flag 0 makes the pending read address equal to the frame's address. The next capture returns that register's value in the data field.
- R4: The mapped addresses and their widths are:
  - 0: debug control, 6 bits
  - 1: debug status, 5 bits
  - 2: vector catch, 8 bits
  - 4: exchange control, 6 bits
  - 5: exchange data, 32 bits
  - 8–11 and 16–19: watchpoint address and data value and mask, 32 bits each
  - 12 and 20: watchpoint control value, 9 bits
  - 13 and 21: watchpoint control mask, 8 bits
- R5: Unmapped addresses read as zero, and writes to them change nothing.
- R6: Captured data bits above a register's width are zero.
- R7: A write to address 5 sets bit 0 of exchange control (word present). A read request for address 5 clears that bit.
- R8: A write update leaves the pending read address unchanged.
- R9: An update that is not preceded by a capture since the last honoured update is ignored, even if a frame was shifted in.
- R10: Active-low `rst_n` clears every register and the pending read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_en | input | 1 | Capture strobe from the TAP |
| shift_en | input | 1 | Shift strobe from the TAP |
| update_en | input | 1 | Update strobe from the TAP |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (frame bit 0) |

## Verification
The bench first writes all ones to every one of the 32 addresses and reads each back. This separates correct width truncation from mapping errors and from leakage into unmapped slots. Directed chains then check the two-scan read latency and the word-present flag set and clear through the exchange-data side effect. They also check that a write leaves the pending address in place. An update after a shift with no capture must be dropped. A reset in the middle of a run must clear every register. Several hundred random scans, mixing reads and writes over all addresses, are compared against a bench model of the register bank and the pending address.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int FRAME_W  = DATA_W + ADDR_W + 1;
    localparam int NUM_ADDR = 1 << ADDR_W;

    localparam int A_XCTL   = 4;   // exchange control
    localparam int A_XDATA  = 5;   // exchange data (read consumes)
    localparam int XPRESENT = 0;   // word-present bit in exchange control

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_SHIFT = 2'd2
    } scan_state_e;

    // packed: first member is most significant, so data sits at bits 0..31
    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic int unsigned reg_width(input int unsigned a);
        case (a)
            0:                              return 6;
            1:                              return 5;
            2:                              return 8;
            4:                              return 6;
            5:                              return 32;
            8, 9, 10, 11, 16, 17, 18, 19:   return 32;
            12, 20:                         return 9;
            13, 21:                         return 8;
            default:                        return 0;
        endcase
    endfunction
endpackage

// File: rtl/dbg_scan_shifter.sv
module dbg_scan_shifter
    import dbg_scan_pkg::*;
#(
    parameter int FRAME_W_P = FRAME_W
) (
    input  logic                 tck,
    input  logic                 rst_n,
    input  logic                 capture_en,
    input  logic                 shift_en,
    input  logic                 update_en,
    input  logic                 tdi,
    input  logic [FRAME_W_P-1:0] cap_word,
    output logic [FRAME_W_P-1:0] frame_q,
    output logic                 upd_fire,
    output scan_state_e          state_q,
    output logic                 tdo
);
    scan_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (capture_en) state_d = S_ARMED;
            end
            S_ARMED: begin
                if (capture_en)     state_d = S_ARMED;
                else if (shift_en)  state_d = S_SHIFT;
                else if (update_en) state_d = S_IDLE;
            end
            S_SHIFT: begin
                if (capture_en)     state_d = S_ARMED;
                else if (shift_en)  state_d = S_SHIFT;
                else if (update_en) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        upd_fire = update_en && !capture_en && !shift_en && (state_q != S_IDLE);
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)          frame_q <= '0;
        else if (capture_en) frame_q <= cap_word;
        else if (shift_en)   frame_q <= {tdi, frame_q[FRAME_W_P-1:1]};
    end

    assign tdo = frame_q[0];
endmodule

// File: rtl/dbg_scan_ctrl.sv
module dbg_scan_ctrl
    import dbg_scan_pkg::*;
(
    input  logic              tck,
    input  logic              rst_n,
    input  logic              upd_fire,
    input  logic [FRAME_W-1:0] frame_q,
    output logic              wr_en,
    output logic              rd_req,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] pend_addr
);
    frame_t fr;

    always_comb begin
        fr       = frame_t'(frame_q);
        acc_addr = fr.addr;
        wr_data  = fr.data;
        wr_en    = upd_fire && fr.wr;
        rd_req   = upd_fire && !fr.wr;
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)      pend_addr <= '0;
        else if (rd_req) pend_addr <= fr.addr;
    end
endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
    import dbg_scan_pkg::*;
(
    input  logic              tck,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [NUM_ADDR-1:0][DATA_W-1:0] rv;

    for (genvar i = 0; i < NUM_ADDR; i++) begin : g_reg
        localparam int W = int'(reg_width(i));
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
        if (W == 0) begin : g_none
            assign rv[i] = '0;
        end else if (i == A_XCTL) begin : g_xctl
            logic [W-1:0] q;
            always_ff @(posedge tck or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en && acc_addr == MY_ADDR) begin
                    q <= wr_data[W-1:0];
                end else if (wr_en && acc_addr == ADDR_W'(A_XDATA)) begin
                    q[XPRESENT] <= 1'b1;
                end else if (rd_req && acc_addr == ADDR_W'(A_XDATA)) begin
                    q[XPRESENT] <= 1'b0;
                end
            end
            assign rv[i] = DATA_W'(q);
        end else begin : g_plain
            logic [W-1:0] q;
            always_ff @(posedge tck or negedge rst_n) begin
                if (!rst_n)                          q <= '0;
                else if (wr_en && acc_addr == MY_ADDR) q <= wr_data[W-1:0];
            end
            assign rv[i] = DATA_W'(q);
        end
    end

    assign rd_data = rv[rd_addr];
endmodule

// File: rtl/dbg_scan_access.sv
module dbg_scan_access
    import dbg_scan_pkg::*;
(
    input  logic tck,
    input  logic rst_n,
    input  logic capture_en,
    input  logic shift_en,
    input  logic update_en,
    input  logic tdi,
    output logic tdo
);
    logic [FRAME_W-1:0] frame_q;
    logic [FRAME_W-1:0] cap_word;
    logic               upd_fire;
    scan_state_e        state_q;
    logic               wr_en;
    logic               rd_req;
    logic [ADDR_W-1:0]  acc_addr;
    logic [DATA_W-1:0]  wr_data;
    logic [ADDR_W-1:0]  pend_addr;
    logic [DATA_W-1:0]  rd_data;

    assign cap_word = {1'b0, pend_addr, rd_data};

    dbg_scan_shifter #(.FRAME_W_P(FRAME_W)) u_shift (
        .tck(tck), .rst_n(rst_n),
        .capture_en(capture_en), .shift_en(shift_en), .update_en(update_en),
        .tdi(tdi), .cap_word(cap_word), .frame_q(frame_q),
        .upd_fire(upd_fire), .state_q(state_q), .tdo(tdo)
    );

    dbg_scan_ctrl u_ctrl (
        .tck(tck), .rst_n(rst_n), .upd_fire(upd_fire), .frame_q(frame_q),
        .wr_en(wr_en), .rd_req(rd_req), .acc_addr(acc_addr),
        .wr_data(wr_data), .pend_addr(pend_addr)
    );

    dbg_regfile u_regs (
        .tck(tck), .rst_n(rst_n), .wr_en(wr_en), .rd_req(rd_req),
        .acc_addr(acc_addr), .wr_data(wr_data),
        .rd_addr(pend_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/dbg_scan_checker.sv
module dbg_scan_checker
    import dbg_scan_pkg::*;
(
    input logic              tck,
    input logic              rst_n,
    input logic              rd_req,
    input logic              wr_en,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [ADDR_W-1:0] pend_addr,
    input logic [DATA_W-1:0] rd_data
);
    assert_read_sets_pending_R3: assert property (@(posedge tck) disable iff (!rst_n)
        rd_req |=> (pend_addr == $past(acc_addr)));

    assert_write_keeps_pending_R8: assert property (@(posedge tck) disable iff (!rst_n)
        wr_en |=> $stable(pend_addr));

    assert_unmapped_zero_R5: assert property (@(posedge tck) disable iff (!rst_n)
        (reg_width(int'(pend_addr)) == 0) |-> (rd_data == '0));

    assert_upper_bits_zero_R6: assert property (@(posedge tck) disable iff (!rst_n)
        (reg_width(int'(pend_addr)) < DATA_W) |->
            ((rd_data >> reg_width(int'(pend_addr))) == '0));

    assert_reset_clears_pending_R10: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(rst_n) |-> (pend_addr == '0 && rd_data == '0));
endmodule

bind dbg_scan_access dbg_scan_checker u_chk (
    .tck(tck), .rst_n(rst_n), .rd_req(rd_req), .wr_en(wr_en),
    .acc_addr(acc_addr), .pend_addr(pend_addr), .rd_data(rd_data)
);

// File: tb/dbg_scan_access_test.sv
module dbg_scan_access_test;
    localparam int CLK_P = 10;
    localparam int FW    = 38;

    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic capture_en = 1'b0;
    logic shift_en = 1'b0;
    logic update_en = 1'b0;
    logic tdi = 1'b0;
    logic tdo;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] model [32];
    logic [4:0]  pend;

    dbg_scan_access uut (
        .tck(tck), .rst_n(rst_n), .capture_en(capture_en), .shift_en(shift_en),
        .update_en(update_en), .tdi(tdi), .tdo(tdo)
    );

    always #(CLK_P/2) tck = ~tck;

    function automatic int bw(input int a);
        if (a == 0 || a == 4) return 6;
        if (a == 1) return 5;
        if (a == 2) return 8;
        if (a == 5) return 32;
        if ((a >= 8 && a <= 11) || (a >= 16 && a <= 19)) return 32;
        if (a == 12 || a == 20) return 9;
        if (a == 13 || a == 21) return 8;
        return 0;
    endfunction

    function automatic logic [31:0] trunc(input logic [31:0] v, input int w);
        if (w >= 32) return v;
        if (w == 0) return 32'h0;
        return v & ((32'h1 << w) - 32'h1);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) model[i] = 32'h0;
        pend = 5'd0;
    endtask

    task automatic model_apply(input logic [31:0] d, input logic [4:0] a, input logic w);
        if (w) begin
            if (bw(int'(a)) != 0) model[a] = trunc(d, bw(int'(a)));
            if (a == 5'd5) model[4][0] = 1'b1;
        end else begin
            pend = a;
            if (a == 5'd5) model[4][0] = 1'b0;
        end
    endtask

    // one full scan: optional capture, 38 shifts, update; compares captured frame
    task automatic scan(input logic [31:0] d, input logic [4:0] a, input logic w,
                        input bit do_cap, input string tag);
        logic [FW-1:0] tx;
        logic [FW-1:0] rx;
        logic [31:0]   exp_d;
        logic [4:0]    exp_a;
        bit            honoured;
        tx = {w, a, d};
        exp_d = trunc(model[pend], bw(int'(pend)));
        exp_a = pend;
        if (do_cap) begin
            @(negedge tck) capture_en = 1'b1;
            @(negedge tck) capture_en = 1'b0;
        end else begin
            @(negedge tck);
        end
        shift_en = 1'b1;
        for (int i = 0; i < FW; i++) begin
            tdi = tx[i];
            rx[i] = tdo;
            @(negedge tck);
        end
        shift_en = 1'b0;
        update_en = 1'b1;
        @(negedge tck) update_en = 1'b0;
        honoured = do_cap;
        if (do_cap) begin
            check(tag, rx[31:0], exp_d);
            check("R1 addr field", {27'h0, rx[36:32]}, {27'h0, exp_a});
            check("R1 flag field", {31'h0, rx[37]}, 32'h0);
        end
        if (honoured) model_apply(d, a, w);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge tck);
        rst_n = 1'b1;
        model_reset();
        @(negedge tck);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        do_reset();

        // R10: reset state, pending address 0 returns debug control = 0
        scan(32'h0, 5'd1, 1'b0, 1'b1, "R10 reset value");

        // R2/R4/R5/R6: write all ones everywhere, then read every address back
        for (int a = 0; a < 32; a++) scan(32'hFFFF_FFFF, 5'(a), 1'b1, 1'b1, "R2 pre-write");
        for (int a = 0; a < 32; a++) scan(32'h0, 5'(a), 1'b0, 1'b1,
                                          (bw(a) == 0) ? "R5 unmapped" : "R4 R6 width");
        scan(32'h0, 5'd4, 1'b0, 1'b1, "R4 R6 last read");

        // R7: exchange data side effect on the present flag
        scan(32'hA5A5_0001, 5'd5, 1'b1, 1'b1, "R7 write data");
        scan(32'h0, 5'd4, 1'b0, 1'b1, "R7 setup");
        scan(32'h0, 5'd5, 1'b0, 1'b1, "R7 present set");
        scan(32'h0, 5'd4, 1'b0, 1'b1, "R7 data returned");
        scan(32'h0, 5'd4, 1'b0, 1'b1, "R7 present cleared");

        // R8: write between read request and capture keeps pending address
        scan(32'h1357_9BDF, 5'd9, 1'b1, 1'b1, "R8 setup");
        scan(32'h0, 5'd9, 1'b0, 1'b1, "R8 setup read");
        scan(32'h0BAD_F00D, 5'd16, 1'b1, 1'b1, "R8 pending value");
        scan(32'h0, 5'd9, 1'b0, 1'b1, "R8 still pending");

        // R9: shift-only frame with update is ignored
        scan(32'h1111_2222, 5'd8, 1'b1, 1'b1, "R9 setup");
        scan(32'h3333_4444, 5'd8, 1'b1, 1'b0, "R9 no capture");
        scan(32'h0, 5'd8, 1'b0, 1'b1, "R9 setup read");
        scan(32'h0, 5'd4, 1'b0, 1'b1, "R9 register unchanged");

        // R10: reset mid-run clears everything
        scan(32'hFFFF_FFFF, 5'd17, 1'b1, 1'b1, "R10 setup");
        scan(32'h0, 5'd17, 1'b0, 1'b1, "R10 setup read");
        do_reset();
        scan(32'h0, 5'd17, 1'b0, 1'b1, "R10 pending cleared");
        scan(32'h0, 5'd0, 1'b0, 1'b1, "R10 register cleared");

        // R3: random mix of reads and writes
        for (int n = 0; n < 300; n++) begin
            logic [31:0] d;
            logic [4:0]  a;
            logic        w;
            d = $urandom;
            a = 5'($urandom_range(0, 31));
            w = 1'($urandom_range(0, 1));
            scan(d, a, w, 1'b1, "R3 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule